// File: doc/BRIEF.md
# I2C Bus Master with CRC-8 Packet Error Checking

This block is a byte-level master for an I2C or SMBus two-wire bus. Software (or a controlling state machine) hands it one command at a time: generate a START or repeated START, send a 7-bit or 10-bit address phase, write a byte, read a byte and answer ACK or NACK, or generate a STOP. The block creates SCL from the system clock, with one of two bus speeds, and drives both wires through open-drain style enables. A 1 on an enable pulls the wire low. A 0 on an enable releases the wire to its pull-up.

A running CRC-8 (polynomial x^8+x^2+x+1, initial value 0x00) sees every byte that crosses the bus while the master owns it, address bytes included. The CRC is shifted MSB first from the sampled SDA value. A write command can append the CRC as a trailing packet-error byte on its own. A read command can treat the byte it receives as the packet-error byte and flag a mismatch.

With several masters on one bus, the block watches every bit it sends with SDA released. If it samples that bit low, it has lost arbitration: it lets go of both wires at once and reports the loss. Error conditions show up on an error interrupt line. Completion of a command is signalled separately by a one-cycle `done` pulse.

Top module: `i2c_pec_master`

## Requirements
- R1: After reset the block is idle (`busy`=0), both line enables are 0, all error flags and `err_irq` are 0, and `pec` is 0x00.
- R2: Each SCL period lasts 4*QTR_FAST clock cycles when `fast_mode`=1, and 4*QTR_STD cycles when `fast_mode`=0. The defaults give 400 kHz and 100 kHz from 125 MHz.
- R3: Command codes are 0 START, 1 address-write, 2 address-read, 3 write byte, 4 read byte and 5 STOP. With `ten_bit`=0, an address command sends the single byte {addr[6:0], R/W}, where R/W is 1 for a read. Every byte goes out MSB first.
- R4: With `ten_bit`=1, an address-write command sends 0b11110,addr[9:8],0 and then addr[7:0], as one command.
- R5: With `ten_bit`=1, an address-read command sends the same two bytes as R4, then a repeated START, then 0b11110,addr[9:8],1, as one command.
- R6: If the slave does not acknowledge an address or write byte (SDA high in the ninth bit), `err_nack` is set. The command ends with SCL released and the bus still held, so that a STOP can follow.
- R7: A read command assembles the received byte MSB first into `rdata`. In the ninth bit it drives SDA low (ACK) when `nack_last`=0 and releases SDA (NACK) when `nack_last`=1.
- R8: `pec` is updated with every byte on the bus, address bytes included. It clears on a START issued from a free bus and is kept across repeated STARTs. After a correct packet-error byte has passed, `pec` reads 0x00.
- R9: A write command with `pec_en`=1 sends the data byte, then the current CRC as a further byte, before it completes.
- R10: A read command with `pec_en`=1 treats the byte as the packet-error byte. If `pec` is not 0x00 once the byte is included, `err_pec` is set in the same cycle as `done`.
- R11: If SDA is sampled low while the master releases it in an address or write bit, the master releases both lines at once, sets `err_arb`, ends the command and leaves the bus free.
- R12: `err_irq` is the OR of the three error flags. The flags stay set until the next START issued from a free bus clears them.
- R13: A command is accepted only while `busy`=0. Codes 6 and 7, and any command offered while busy, have no effect.
- R14: `done` is a one-cycle pulse at the end of every accepted command, and `busy` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 selects the fast SCL rate, 0 the standard rate |
| ten_bit | input | 1 | 1 selects 10-bit address sequencing |
| addr | input | 10 | Target address, sampled when an address command is accepted |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | Command code (see R3) |
| wdata | input | 8 | Byte to send for a write command |
| nack_last | input | 1 | Read: answer NACK instead of ACK |
| pec_en | input | 1 | Write: append the CRC byte. Read: check the byte as the CRC |
| busy | output | 1 | A command is executing |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte received |
| pec | output | 8 | Running CRC-8 value |
| err_arb | output | 1 | Arbitration lost |
| err_nack | output | 1 | Slave did not acknowledge |
| err_pec | output | 1 | Packet-error byte mismatch |
| err_irq | output | 1 | Error interrupt, OR of the flags |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sensed level of the SDA wire |

## Verification
The following rules are checked on every cycle:
- commands are accepted only while idle, and unused codes are refused;
- SCL is always released whenever the engine is idle;
- `done` never coincides with `busy`;
- an arbitration loss leaves both wires released in the same cycle the flag rises;
- a CRC mismatch or a missing acknowledge is reported together with command completion.

Other behaviour depends on a slave on the bus, so only the bench scenarios can show it. This covers the exact bytes seen on the wire, the 10-bit address sequences with their repeated START, the CRC value and the byte appended to a write, the ACK/NACK answers given on reads, and the two SCL periods.

// File: rtl/i2c_pec_master.sv
module i2c_pec_master #(
  parameter int QTR_STD  = 313,
  parameter int QTR_FAST = 79
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_mode,
  input  logic       ten_bit,
  input  logic [9:0] addr,
  input  logic       cmd_valid,
  input  logic [2:0] cmd,
  input  logic [7:0] wdata,
  input  logic       nack_last,
  input  logic       pec_en,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic [7:0] pec,
  output logic       err_arb,
  output logic       err_nack,
  output logic       err_pec,
  output logic       err_irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam int CW = $clog2(QTR_STD + 1);
  localparam logic [CW-1:0] LIM_STD  = CW'(QTR_STD - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(QTR_FAST - 1);
  localparam logic [2:0] C_START = 3'd0, C_ADDR_R = 3'd2,
                         C_WRITE = 3'd3, C_READ = 3'd4, C_STOP = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} state_t;

  state_t        st;
  logic [2:0]    op;
  logic [1:0]    step, ph;
  logic [3:0]    bitn;
  logic [7:0]    sh;
  logic [CW-1:0] cnt;
  logic [9:0]    addr_r;
  logic [1:0]    sync;
  logic          ten_r, nack_r, pec_r, on_bus;
  logic          tick, txbit, smp, fb;

  assign busy    = st != S_IDLE;
  assign err_irq = err_arb | err_nack | err_pec;
  assign tick    = busy && (cnt == (fast_mode ? LIM_FAST : LIM_STD));
  assign smp     = sync[1];
  assign fb      = pec[7] ^ smp;
  assign txbit   = (bitn < 4'd8) ? (op == C_READ || sh[7]) : (op != C_READ || nack_r);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  op <= '0;  step <= '0;  ph <= '0;  bitn <= '0;
      sh <= '0;  cnt <= '0;  addr_r <= '0;  rdata <= '0;  pec <= '0;
      ten_r <= 1'b0;  nack_r <= 1'b0;  pec_r <= 1'b0;  on_bus <= 1'b0;
      err_arb <= 1'b0;  err_nack <= 1'b0;  err_pec <= 1'b0;
      done <= 1'b0;  scl_oe <= 1'b0;  sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid && cmd <= C_STOP) begin
          op <= cmd;  step <= '0;  ph <= '0;  cnt <= '0;  bitn <= '0;
          ten_r <= ten_bit;  addr_r <= addr;  nack_r <= nack_last;  pec_r <= pec_en;
          sh <= (cmd == C_WRITE) ? wdata :
                (cmd == C_READ)  ? 8'hFF :
                ten_bit          ? {5'b11110, addr[9:8], 1'b0} :
                                   {addr[6:0], cmd == C_ADDR_R};
          st <= (cmd == C_START) ? S_START : (cmd == C_STOP) ? S_STOP : S_BIT;
          if (cmd == C_START && !on_bus) begin
            pec <= '0;  err_arb <= 1'b0;  err_nack <= 1'b0;  err_pec <= 1'b0;
          end
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        ph  <= ph + 2'd1;
        unique case (st)
          S_START:
            case (ph)
              2'd0: scl_oe <= on_bus;
              2'd1: sda_oe <= 1'b0;
              2'd2: scl_oe <= 1'b0;
              default: begin
                sda_oe <= 1'b1;
                on_bus <= 1'b1;
                if (op == C_ADDR_R && step == 2'd2) begin
                  st <= S_BIT;  step <= 2'd3;  bitn <= '0;
                  sh <= {5'b11110, addr_r[9:8], 1'b1};
                end else begin
                  st <= S_IDLE;  done <= 1'b1;
                end
              end
            endcase
          S_STOP:
            case (ph)
              2'd0: scl_oe <= 1'b1;
              2'd1: sda_oe <= 1'b1;
              2'd2: scl_oe <= 1'b0;
              default: begin
                sda_oe <= 1'b0;  on_bus <= 1'b0;  st <= S_IDLE;  done <= 1'b1;
              end
            endcase
          S_BIT:
            case (ph)
              2'd0: scl_oe <= 1'b1;
              2'd1: sda_oe <= !txbit;
              2'd2: scl_oe <= 1'b0;
              default: begin
                bitn <= bitn + 4'd1;
                if (bitn < 4'd8) begin
                  sh  <= {sh[6:0], smp};
                  pec <= {pec[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
                  if (op != C_READ && sh[7] && !smp) begin
                    st <= S_IDLE;  done <= 1'b1;  err_arb <= 1'b1;
                    on_bus <= 1'b0;  sda_oe <= 1'b0;  scl_oe <= 1'b0;
                  end
                end else if (op == C_READ) begin
                  rdata <= sh;  st <= S_IDLE;  done <= 1'b1;
                  if (pec_r && pec != 8'd0) err_pec <= 1'b1;
                end else if (smp) begin
                  err_nack <= 1'b1;  st <= S_IDLE;  done <= 1'b1;
                end else if (op == C_WRITE && pec_r && step == 2'd0) begin
                  sh <= pec;  step <= 2'd1;  bitn <= '0;
                end else if (op != C_WRITE && ten_r && step == 2'd0) begin
                  sh <= addr_r[7:0];  step <= 2'd1;  bitn <= '0;
                end else if (op == C_ADDR_R && ten_r && step == 2'd1) begin
                  st <= S_START;  step <= 2'd2;
                end else begin
                  st <= S_IDLE;  done <= 1'b1;
                end
              end
            endcase
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_pec_master_chk.sv
module i2c_pec_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd,
  input logic       busy,
  input logic       done,
  input logic       err_arb,
  input logic       err_nack,
  input logic       err_pec,
  input logic       scl_oe,
  input logic       sda_oe
);
  a_r13_accept_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd <= 3'd5 |=> busy);

  a_r13_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd > 3'd5 |=> !busy);

  a_r14_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_arb) |-> !scl_oe && !sda_oe && !busy && done);

  a_r6_idle_scl_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_oe);

  a_r6_nack_ends_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_nack) |-> done);

  a_r10_pec_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_pec) |-> done);
endmodule

bind i2c_pec_master i2c_pec_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .busy(busy),
  .done(done), .err_arb(err_arb), .err_nack(err_nack), .err_pec(err_pec),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/i2c_pec_master_test.sv
module i2c_pec_master_test;
  localparam int QS = 313, QF = 79;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       fast_mode = 1'b1, ten_bit = 1'b0, cmd_valid = 1'b0;
  logic       nack_last = 1'b0, pec_en = 1'b0;
  logic [9:0] addr = '0;
  logic [2:0] cmd = '0;
  logic [7:0] wdata = '0;
  logic       busy, done, err_arb, err_nack, err_pec, err_irq, scl_oe, sda_oe;
  logic [7:0] rdata, pec;
  logic       scl_bus, sda_bus;

  logic       s_drive = 1'b0, other_drive = 1'b0, s_ack = 1'b1;

  assign scl_bus = !scl_oe;
  assign sda_bus = !(sda_oe || s_drive || other_drive);

  i2c_pec_master uut (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .ten_bit(ten_bit), .addr(addr),
    .cmd_valid(cmd_valid), .cmd(cmd), .wdata(wdata), .nack_last(nack_last), .pec_en(pec_en),
    .busy(busy), .done(done), .rdata(rdata), .pec(pec), .err_arb(err_arb),
    .err_nack(err_nack), .err_pec(err_pec), .err_irq(err_irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_bus)
  );

  int errors = 0, checks = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic f;
      f = c[7] ^ b[i];
      c = {c[6:0], 1'b0} ^ (f ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  // slave model on the shared wires
  int nstart = 0, nlog = 0, nmack = 0, rdi = 0, bitc = 0;
  logic [7:0] rx = '0, tx = '0;
  logic [7:0] logb [0:31];
  logic       mack [0:7];
  logic [7:0] rdq  [0:7];
  bit first = 0, reading = 0;
  logic pscl = 1'b1, psda = 1'b1;

  always @(negedge clk) begin
    if (scl_bus && pscl && psda && !sda_bus) begin
      nstart++;  bitc = 0;  first = 1;  reading = 0;  s_drive = 1'b0;
    end else if (scl_bus && !pscl) begin
      if (bitc < 8) begin
        rx = {rx[6:0], sda_bus};
        bitc++;
        if (bitc == 8 && nlog < 32) begin logb[nlog] = rx; nlog++; end
      end else if (bitc == 8) begin
        if (reading) begin
          if (nmack < 8) begin mack[nmack] = sda_bus; nmack++; end
          if (sda_bus) reading = 0;
          else begin tx = rdq[rdi]; rdi++; end
        end else if (first && rx[0] && s_ack) begin
          reading = 1;  tx = rdq[rdi];  rdi++;
        end
        first = 0;
        bitc = 9;
      end
    end else if (!scl_bus && pscl) begin
      if (bitc == 9) bitc = 0;
      if (bitc == 8)     s_drive = !reading && s_ack;
      else if (bitc < 8) s_drive = reading && !tx[7-bitc];
    end
    pscl = scl_bus;
    psda = sda_bus;
  end

  task automatic issue(input logic [2:0] c, input logic [7:0] d, input logic nk, input logic pe);
    @(negedge clk);
    cmd_valid = 1'b1;  cmd = c;  wdata = d;  nack_last = nk;  pec_en = pe;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run(input logic [2:0] c, input logic [7:0] d, input logic nk, input logic pe);
    issue(c, d, nk, pe);
    wait_done();
  endtask

  task automatic scl_fall(output int n);
    bit seen;
    logic p;
    seen = 0;
    n = 0;
    while (!seen) begin
      p = scl_bus;
      @(negedge clk);
      n++;
      seen = p && !scl_bus;
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 err_irq", err_irq, 0);
    chk("R1 pec", pec, 0);
  endtask

  task automatic t_unused_code();
    issue(3'd6, 8'h00, 0, 0);
    chk("R13 code6 ignored", busy, 0);
    issue(3'd7, 8'h00, 0, 0);
    chk("R13 code7 ignored", busy, 0);
    chk("R13 lines untouched", {scl_oe, sda_oe}, 0);
  endtask

  task automatic t_write7_pec();
    int l0, s0;
    logic [7:0] c;
    fast_mode = 1;  ten_bit = 0;  addr = 10'h03A;  s_ack = 1;
    l0 = nlog;  s0 = nstart;
    run(3'd0, 8'h00, 0, 0);
    @(negedge clk);
    chk("R14 done one cycle", done, 0);
    run(3'd1, 8'h00, 0, 0);
    issue(3'd3, 8'hC5, 0, 0);
    repeat (20) @(negedge clk);
    issue(3'd5, 8'h00, 0, 0);
    wait_done();
    run(3'd3, 8'h5C, 0, 1);
    run(3'd5, 8'h00, 0, 0);
    c = crc8(crc8(crc8(8'h00, 8'h74), 8'hC5), 8'h5C);
    chk("R3/R13 byte count", nlog - l0, 4);
    chk("R3 7-bit address byte", logb[l0], 8'h74);
    chk("R3 data byte", logb[l0+1], 8'hC5);
    chk("R9 data before pec", logb[l0+2], 8'h5C);
    chk("R9 appended pec", logb[l0+3], c);
    chk("R8 pec residue zero", pec, 0);
    chk("R3 one start", nstart - s0, 1);
    chk("R12 no error", err_irq, 0);
  endtask

  task automatic t_speed(input logic fm, input int exp);
    int n;
    fast_mode = fm;  ten_bit = 0;  addr = 10'h03A;  s_ack = 1;
    run(3'd0, 8'h00, 0, 0);
    issue(3'd1, 8'h00, 0, 0);
    scl_fall(n);
    scl_fall(n);
    chk(fm ? "R2 fast SCL period" : "R2 std SCL period", n, exp);
    wait_done();
    run(3'd5, 8'h00, 0, 0);
    fast_mode = 1;
  endtask

  task automatic t_ten_write();
    int l0;
    ten_bit = 1;  addr = 10'h2D6;  s_ack = 1;  l0 = nlog;
    run(3'd0, 8'h00, 0, 0);
    run(3'd1, 8'h00, 0, 0);
    run(3'd3, 8'h11, 0, 0);
    run(3'd5, 8'h00, 0, 0);
    chk("R4 header byte", logb[l0], 8'hF4);
    chk("R4 low address", logb[l0+1], 8'hD6);
    chk("R4 data after address", logb[l0+2], 8'h11);
    chk("R4 no nack", err_nack, 0);
  endtask

  task automatic t_ten_read();
    int l0, s0, m0;
    logic [7:0] c;
    ten_bit = 1;  addr = 10'h1A3;  s_ack = 1;
    c = crc8(crc8(crc8(crc8(8'h00, 8'hF2), 8'hA3), 8'hF3), 8'h96);
    rdq[0] = 8'h96;  rdq[1] = c;  rdi = 0;
    l0 = nlog;  s0 = nstart;  m0 = nmack;
    run(3'd0, 8'h00, 0, 0);
    run(3'd2, 8'h00, 0, 0);
    chk("R5 repeated start", nstart - s0, 2);
    chk("R5 header write", logb[l0], 8'hF2);
    chk("R5 low address", logb[l0+1], 8'hA3);
    chk("R5 header read", logb[l0+2], 8'hF3);
    run(3'd4, 8'h00, 0, 0);
    chk("R7 rdata", rdata, 8'h96);
    run(3'd4, 8'h00, 1, 1);
    chk("R7 pec byte read", rdata, c);
    chk("R10 good pec no error", err_pec, 0);
    chk("R8 pec residue after read", pec, 0);
    chk("R7 master ack", mack[m0], 0);
    chk("R7 master nack", mack[m0+1], 1);
    run(3'd5, 8'h00, 0, 0);
  endtask

  task automatic t_pec_bad();
    ten_bit = 0;  addr = 10'h021;  s_ack = 1;
    rdq[0] = 8'h40;  rdq[1] = crc8(crc8(8'h00, 8'h43), 8'h40) ^ 8'h01;  rdi = 0;
    run(3'd0, 8'h00, 0, 0);
    run(3'd2, 8'h00, 0, 0);
    run(3'd4, 8'h00, 0, 0);
    chk("R7 7-bit read data", rdata, 8'h40);
    run(3'd4, 8'h00, 1, 1);
    chk("R10 bad pec flagged", err_pec, 1);
    chk("R12 irq on pec", err_irq, 1);
    run(3'd5, 8'h00, 0, 0);
    chk("R12 flag sticky", err_pec, 1);
  endtask

  task automatic t_nack();
    ten_bit = 0;  addr = 10'h03A;  s_ack = 0;
    run(3'd0, 8'h00, 0, 0);
    chk("R12 cleared on start", err_irq, 0);
    run(3'd1, 8'h00, 0, 0);
    chk("R6 nack flag", err_nack, 1);
    chk("R6 scl released", scl_oe, 0);
    chk("R6 idle after nack", busy, 0);
    run(3'd5, 8'h00, 0, 0);
    chk("R6 stop after nack", {scl_oe, sda_oe}, 0);
    s_ack = 1;
  endtask

  task automatic t_arb();
    int l0;
    ten_bit = 0;  addr = 10'h050;  s_ack = 1;
    run(3'd0, 8'h00, 0, 0);
    other_drive = 1'b1;
    l0 = nlog;
    run(3'd1, 8'h00, 0, 0);
    chk("R11 arb flag", err_arb, 1);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
    chk("R11 idle", busy, 0);
    chk("R11 stopped after one bit", nlog - l0, 0);
    chk("R12 irq on arb", err_irq, 1);
    repeat (10) @(negedge clk);
    other_drive = 1'b0;
    repeat (10) @(negedge clk);
    run(3'd0, 8'h00, 0, 0);
    chk("R12 arb cleared by start", err_arb, 0);
    run(3'd5, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unused_code();
    t_write7_pec();
    t_speed(1'b1, 4 * QF);
    t_speed(1'b0, 4 * QS);
    t_ten_write();
    t_ten_read();
    t_pec_bad();
    t_nack();
    t_arb();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule